// File: doc/BRIEF.md
# Radix-2² Delay-Feedback Butterfly Stage

This block is one stage of a pipelined FFT built from single-path delay-feedback butterflies. Complex samples arrive one per valid cycle in natural order. Two butterflies are chained inside the stage. Each butterfly holds earlier samples in its own feedback delay line and combines them with later ones. The first butterfly pairs samples `LEN` apart. The second butterfly pairs samples `LEN/2` apart, and it folds in a rotation by −j without a multiplier: it swaps the real and imaginary parts and exchanges its add and subtract operations.

Each stage sub-frame has `2*LEN` samples. The two most significant bits of a shared frame counter tell the stage which phase it is in. These bits come in on `in_sel`, and `in_sel` must describe the index of the sample currently offered. The stage keeps no counter of its own, so several stages can share one. Consecutive frames can follow with no idle slots. The differences parked in the delay line leave while the first half of the next frame is being loaded.

A full transform chains stages of shrinking `LEN`, with a general twiddle multiplier between them. That multiplier is outside this block. The results leave in bit-reversed order.

Top module: `sdf22_stage`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid` is 0 and `out_re`/`out_im` are 0.
- R2: Each cycle with `in_valid` high produces exactly one cycle with `out_valid` high, two clock cycles later. Without `in_valid`, no output is produced and `out_re`/`out_im` keep their value. Data on the inputs in such cycles is ignored.
- R3: First butterfly. When `in_sel[1]`=0 the sample is written into a `LEN`-deep delay line, and the value leaving that line moves on. When `in_sel[1]`=1 the sum (earlier + current) moves on, and the difference (earlier − current) enters the delay line.
- R4: Second butterfly. It works on the first butterfly's output, one valid cycle later, with a `LEN/2`-deep delay line. Its fill/compute choice is the `in_sel[0]` that came with the originating sample. It produces sum forward and difference (earlier − later) stored, as in R3.
- R5: When the originating sample had `in_sel`=2'b01, the second butterfly multiplies its later operand by −j (re,im → im,−re) before combining.
- R6: Let the k-th valid output (counting from 0, with the k-th valid input carrying frame index k mod 2·LEN on `in_sel`) be item p = (k − 3·LEN/2) mod 2·LEN of its frame. Write p = LEN·a + (LEN/2)·b + c, and y_e = x[c+e·LEN/2] + (−1)^a·x[c+e·LEN/2+LEN] for e = 0,1. Apply −j to y_1 when a=1. Then item p = y_0 + (−1)^b·y_1.
- R7: Frames follow each other without idle cycles, and every frame after the first obeys R6 exactly.
- R8: With `SCALE`=0 the output is `DW`+2 bits wide and exact for every `DW`-bit input, including full-scale positive and negative frames.
- R9: With `SCALE`=1 the output is `DW` bits wide. Each butterfly result is halved with rounding toward minus infinity (arithmetic shift right by one).
- R10: Idle cycles inserted between valid samples do not change any output value or its order.
- R11: Two stages (`LEN`=8, then `LEN`=2) give a 16-point DFT of the input frame, in bit-reversed order, within ±4 per component. Between them, item p is multiplied by e^(−j2π·c·(a+2b)/16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample valid |
| in_sel | input | 2 | Top two bits of the frame index of the offered sample (bit 1 = MSB) |
| in_re | input | DW | Input real part, two's complement |
| in_im | input | DW | Input imaginary part, two's complement |
| out_valid | output | 1 | Output sample valid |
| out_re | output | DW+2 (DW if SCALE=1) | Output real part |
| out_im | output | DW+2 (DW if SCALE=1) | Output imaginary part |

## Verification
The bench builds the stage three times. The first build uses `DW`=10, `LEN`=8, `SCALE`=0, fed back to back. The second uses the same sizes with `SCALE`=1 and idle cycles inserted. The third uses `DW`=13, `LEN`=2, and follows the first through a rounded twiddle so that the pair forms a 16-point transform. With 16-point frames, an impulse can be placed at every input position, and every output item, the −j quarter and both extreme amplitudes are checked exactly against arithmetic done in the bench. The chained pair is compared with a directly summed DFT.

// File: rtl/sdf22_pkg.sv
package sdf22_pkg;

  // Butterfly phase: park samples in the feedback line, or combine them.
  typedef enum logic {
    BF_FILL = 1'b0,
    BF_CALC = 1'b1
  } bf_mode_e;

  // Address width for a delay line, never below one bit.
  function automatic int unsigned line_aw(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/sdf_fb_line.sv
module sdf_fb_line #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data
);
  import sdf22_pkg::*;

  localparam int AW = line_aw(DEPTH);

  generate
    if (DEPTH == 1) begin : g_reg
      logic [W-1:0] hold_q;
      always_ff @(posedge clk) begin
        if (rst)     hold_q <= '0;
        else if (en) hold_q <= wr_data;
      end
      assign rd_data = hold_q;
    end else begin : g_ram
      // Circular buffer: the word read at ptr is the one written DEPTH
      // enables earlier, and is overwritten on the same enable.
      logic [W-1:0]  mem [DEPTH];
      logic [AW-1:0] ptr;

      always_ff @(posedge clk) begin
        if (en) mem[ptr] <= wr_data;
      end

      always_ff @(posedge clk) begin
        if (rst)                         ptr <= '0;
        else if (en && ptr == AW'(DEPTH-1)) ptr <= '0;
        else if (en)                     ptr <= ptr + 1'b1;
      end

      assign rd_data = mem[ptr];
    end
  endgenerate

endmodule

// File: rtl/sdf_bf.sv
module sdf_bf #(
  parameter int IW    = 16,
  parameter int DEPTH = 8,
  parameter bit SCALE = 1'b0,
  parameter bit ROT   = 1'b0
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 en,
  input  logic                                 calc,
  input  logic                                 rot,
  input  logic signed [IW-1:0]                 a_re,
  input  logic signed [IW-1:0]                 a_im,
  output logic                                 o_v,
  output logic signed [IW+(SCALE ? 0 : 1)-1:0] o_re,
  output logic signed [IW+(SCALE ? 0 : 1)-1:0] o_im
);
  import sdf22_pkg::*;

  localparam int OW = IW + (SCALE ? 0 : 1);
  localparam int SW = IW + 1;

  bf_mode_e mode;
  assign mode = bf_mode_e'(calc);

  logic [2*OW-1:0]      fb_rd, fb_wr;
  logic signed [OW-1:0] fb_re, fb_im;
  logic signed [IW-1:0] x_re, x_im;
  logic                 flip;

  sdf_fb_line #(.W(2*OW), .DEPTH(DEPTH)) u_line (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .wr_data (fb_wr),
    .rd_data (fb_rd)
  );

  assign fb_re = $signed(fb_rd[2*OW-1:OW]);
  assign fb_im = $signed(fb_rd[OW-1:0]);

  // Trivial rotation by -j: swap the parts, then exchange the add and
  // subtract on the imaginary path (re' = im, im' = -re).
  generate
    if (ROT) begin : g_rot
      assign x_re = rot ? a_im : a_re;
      assign x_im = rot ? a_re : a_im;
      assign flip = rot;
    end else begin : g_plain
      logic unused_rot;
      assign unused_rot = rot;
      assign x_re = a_re;
      assign x_im = a_im;
      assign flip = 1'b0;
    end
  endgenerate

  logic signed [SW-1:0] sum_re, sum_im, dif_re, dif_im;

  always_comb begin
    sum_re = SW'(fb_re) + SW'(x_re);
    dif_re = SW'(fb_re) - SW'(x_re);
    if (flip) begin
      sum_im = SW'(fb_im) - SW'(x_im);
      dif_im = SW'(fb_im) + SW'(x_im);
    end else begin
      sum_im = SW'(fb_im) + SW'(x_im);
      dif_im = SW'(fb_im) - SW'(x_im);
    end
  end

  logic signed [OW-1:0] sum_s_re, sum_s_im, dif_s_re, dif_s_im;

  generate
    if (SCALE) begin : g_half
      assign sum_s_re = sum_re[SW-1:1];
      assign sum_s_im = sum_im[SW-1:1];
      assign dif_s_re = dif_re[SW-1:1];
      assign dif_s_im = dif_im[SW-1:1];
    end else begin : g_grow
      assign sum_s_re = sum_re;
      assign sum_s_im = sum_im;
      assign dif_s_re = dif_re;
      assign dif_s_im = dif_im;
    end
  endgenerate

  always_comb begin
    if (mode == BF_CALC) fb_wr = {dif_s_re, dif_s_im};
    else                 fb_wr = {OW'(a_re), OW'(a_im)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_v  <= 1'b0;
      o_re <= '0;
      o_im <= '0;
    end else begin
      o_v <= en;
      if (en) begin
        if (mode == BF_CALC) begin
          o_re <= sum_s_re;
          o_im <= sum_s_im;
        end else begin
          o_re <= fb_re;
          o_im <= fb_im;
        end
      end
    end
  end

endmodule

// File: rtl/sdf22_stage.sv
module sdf22_stage #(
  parameter int DW    = 16,
  parameter int LEN   = 8,
  parameter bit SCALE = 1'b0
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 in_valid,
  input  logic [1:0]                           in_sel,
  input  logic signed [DW-1:0]                 in_re,
  input  logic signed [DW-1:0]                 in_im,
  output logic                                 out_valid,
  output logic signed [DW+(SCALE ? 0 : 2)-1:0] out_re,
  output logic signed [DW+(SCALE ? 0 : 2)-1:0] out_im
);

  localparam int MW   = DW + (SCALE ? 0 : 1);
  localparam int HALF = LEN / 2;

  logic                 mid_v;
  logic signed [MW-1:0] mid_re, mid_im;
  logic [1:0]           sel_d;
  logic                 rot_en;

  sdf_bf #(.IW(DW), .DEPTH(LEN), .SCALE(SCALE), .ROT(1'b0)) u_bf_a (
    .clk  (clk),
    .rst  (rst),
    .en   (in_valid),
    .calc (in_sel[1]),
    .rot  (1'b0),
    .a_re (in_re),
    .a_im (in_im),
    .o_v  (mid_v),
    .o_re (mid_re),
    .o_im (mid_im)
  );

  // Phase bits travel with the sample into the second butterfly.
  always_ff @(posedge clk) begin
    if (rst)           sel_d <= 2'b00;
    else if (in_valid) sel_d <= in_sel;
  end

  // -j applies to the second quarter of the difference half of the
  // first butterfly's output frame.
  assign rot_en = ~sel_d[1] & sel_d[0];

  sdf_bf #(.IW(MW), .DEPTH(HALF), .SCALE(SCALE), .ROT(1'b1)) u_bf_b (
    .clk  (clk),
    .rst  (rst),
    .en   (mid_v),
    .calc (sel_d[0]),
    .rot  (rot_en),
    .a_re (mid_re),
    .a_im (mid_im),
    .o_v  (out_valid),
    .o_re (out_re),
    .o_im (out_im)
  );

endmodule

// File: rtl/sdf22_stage_chk.sv
module sdf22_stage_chk #(
  parameter int OW = 18
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          mid_v,
  input logic          out_valid,
  input logic [OW-1:0] out_re,
  input logic [OW-1:0] out_im
);

  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst)              age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !mid_v && out_re == '0 && out_im == '0));

  // R2
  mid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1) |-> (mid_v == $past(in_valid)));

  // R2
  out_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1) |-> (out_valid == $past(mid_v)));

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1 && !out_valid) |-> ($stable(out_re) && $stable(out_im)));

endmodule

bind sdf22_stage sdf22_stage_chk #(.OW(DW + (SCALE ? 0 : 2))) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .mid_v     (mid_v),
  .out_valid (out_valid),
  .out_re    (out_re),
  .out_im    (out_im)
);

// File: tb/test_sdf22_stage.sv
`timescale 1ns/1ps
module test_sdf22_stage;
  localparam int N   = 16;
  localparam int NF  = 24;
  localparam int DW1 = 10;
  localparam int DW2 = 13;
  localparam int ML  = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  // full-growth stage, LEN=8
  logic v1 = 0; logic [1:0] sel1 = 0;
  logic signed [DW1-1:0] re1 = 0, im1 = 0;
  logic ov1; logic signed [DW1+1:0] or1, oi1;
  // halving stage, LEN=8
  logic vs = 0; logic [1:0] sels = 0;
  logic signed [DW1-1:0] res = 0, ims = 0;
  logic ovs; logic signed [DW1-1:0] ors, ois;
  // second stage, LEN=2
  logic v2 = 0; logic [1:0] sel2 = 0;
  logic signed [DW2-1:0] re2 = 0, im2 = 0;
  logic ov2; logic signed [DW2+1:0] or2, oi2;

  sdf22_stage #(.DW(DW1), .LEN(8), .SCALE(1'b0)) i_sdf22_stage (
    .clk(clk), .rst(rst), .in_valid(v1), .in_sel(sel1), .in_re(re1), .in_im(im1),
    .out_valid(ov1), .out_re(or1), .out_im(oi1));
  sdf22_stage #(.DW(DW1), .LEN(8), .SCALE(1'b1)) i_sdf22_stage_half (
    .clk(clk), .rst(rst), .in_valid(vs), .in_sel(sels), .in_re(res), .in_im(ims),
    .out_valid(ovs), .out_re(ors), .out_im(ois));
  sdf22_stage #(.DW(DW2), .LEN(2), .SCALE(1'b0)) i_sdf22_stage_s2 (
    .clk(clk), .rst(rst), .in_valid(v2), .in_sel(sel2), .in_re(re2), .in_im(im2),
    .out_valid(ov2), .out_re(or2), .out_im(oi2));

  int xr [NF*N];
  int xi [NF*N];
  int o1r [ML]; int o1i [ML]; int n1 = 0;
  int osr [ML]; int osi [ML]; int ns = 0;
  int o2r [ML]; int o2i [ML]; int n2 = 0;
  int t2r [ML]; int t2i [ML];
  int stamp [ML]; int ks = 0;
  int cyc = 0;
  int lat_bad = 0, hold_bad = 0;
  int last_r = 0, last_i = 0;
  int checks = 0, bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (ov1 && n1 < ML) begin o1r[n1] = int'(or1); o1i[n1] = int'(oi1); n1++; end
      if (ov2 && n2 < ML) begin o2r[n2] = int'(or2); o2i[n2] = int'(oi2); n2++; end
      if (ovs) begin
        if (ns < ML) begin
          osr[ns] = int'(ors); osi[ns] = int'(ois);
          if (ns < ks && cyc - stamp[ns] != 2) lat_bad++;
        end
        ns++;
        last_r = int'(ors); last_i = int'(ois);
      end else if (int'(ors) != last_r || int'(ois) != last_i) begin
        hold_bad++;
      end
    end
  end

  task automatic chk(input string tag, input int gr, input int gi, input int er, input int ei);
    checks++;
    if (gr != er || gi != ei) begin
      bad++;
      $display("FAIL %s got (%0d,%0d) expected (%0d,%0d)", tag, gr, gi, er, ei);
    end
  endtask

  function automatic int hv(input int f, input int i, input int s);
    int v;
    v = f * 7919 + i * 104729 + s * 15485863 + 12345;
    v = v ^ (v >>> 7);
    v = v * 1103515245 + 12345;
    return ((v >>> 8) & 1023) - 512;
  endfunction

  task automatic pat(input int f, input int i, output int r, output int m);
    if (f < 16)       begin r = (i == f) ? 300 : 0; m = (i == f) ? -200 : 0; end
    else if (f == 16) begin r = 511;  m = 511;  end
    else if (f == 17) begin r = -512; m = -512; end
    else if (f == 18) begin r = (i % 2 != 0) ? -512 : 511; m = (i % 4 < 2) ? 255 : -256; end
    else              begin r = hv(f, i, 1); m = hv(f, i, 2); end
  endtask

  // Expected stage item p of frame f from the R6 formula; halving per R9.
  task automatic exp_item(input int f, input int p, input bit sc, output int er, output int ei);
    int a, b, c, u, w, tr, yr0, yi0, yr1, yi1;
    a = p / 8; b = (p / 4) % 2; c = p % 4;
    u = f * N + c; w = u + 8;
    yr0 = a ? xr[u] - xr[w] : xr[u] + xr[w];
    yi0 = a ? xi[u] - xi[w] : xi[u] + xi[w];
    u = u + 4; w = w + 4;
    yr1 = a ? xr[u] - xr[w] : xr[u] + xr[w];
    yi1 = a ? xi[u] - xi[w] : xi[u] + xi[w];
    if (sc) begin yr0 = yr0 >>> 1; yi0 = yi0 >>> 1; yr1 = yr1 >>> 1; yi1 = yi1 >>> 1; end
    if (a == 1) begin tr = yr1; yr1 = yi1; yi1 = -tr; end
    er = b ? yr0 - yr1 : yr0 + yr1;
    ei = b ? yi0 - yi1 : yi0 + yi1;
    if (sc) begin er = er >>> 1; ei = ei >>> 1; end
  endtask

  function automatic string item_tag(input int p);
    if (p / 8 == 1)       return "R5";
    if ((p / 4) % 2 == 1) return "R4";
    return "R3";
  endfunction

  function automatic int rnd(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL R2 watchdog got (running) expected (finished)");
      finish_run();
    end
  end

  initial begin
    int er, ei, fm, tag_f;
    for (int f = 0; f < NF; f++)
      for (int i = 0; i < N; i++) pat(f, i, xr[f*N+i], xi[f*N+i]);

    repeat (4) @(negedge clk);
    // R1: reset state of all three builds
    chk("R1 reset full", int'(ov1), int'(or1) | int'(oi1), 0, 0);
    chk("R1 reset half", int'(ovs), int'(ors) | int'(ois), 0, 0);
    chk("R1 reset s2",   int'(ov2), int'(or2) | int'(oi2), 0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", int'(ov1) + int'(ovs) + int'(ov2), 0, 0, 0);

    // back-to-back frames into the full-growth stage
    for (int t = 0; t < NF*N + 12; t++) begin
      v1 = 1'b1; sel1 = 2'((t % N) >> 2);
      re1 = (t < NF*N) ? DW1'(xr[t]) : '0;
      im1 = (t < NF*N) ? DW1'(xi[t]) : '0;
      @(negedge clk);
    end
    v1 = 1'b0; re1 = 10'sd77; im1 = -10'sd33;
    repeat (4) @(negedge clk);

    // halving stage with idle cycles carrying junk data
    for (int t = 0; t < NF*N + 12; t++) begin
      if (t % 3 == 1) begin
        vs = 1'b0; sels = 2'b11; res = 10'sd123; ims = -10'sd321;
        @(negedge clk);
      end
      vs = 1'b1; sels = 2'((t % N) >> 2);
      res = (t < NF*N) ? DW1'(xr[t]) : '0;
      ims = (t < NF*N) ? DW1'(xi[t]) : '0;
      stamp[ks] = cyc; ks++;
      @(negedge clk);
    end
    vs = 1'b0; res = 10'sd55; ims = 10'sd66;
    repeat (4) @(negedge clk);

    // full-growth stage: every item of every frame
    chk("R2 full-stage output count", n1, 0, NF*N + 12, 0);
    for (int f = 0; f < NF; f++) begin
      fm = 0;
      for (int p = 0; p < N; p++) begin
        exp_item(f, p, 1'b0, er, ei);
        tag_f = f * N + 12 + p;
        if (o1r[tag_f] != er || o1i[tag_f] != ei) fm++;
        if (f == 16 || f == 17)
          chk($sformatf("R8 R6 %s extreme frame %0d item %0d", item_tag(p), f, p), o1r[tag_f], o1i[tag_f], er, ei);
        else
          chk($sformatf("R6 %s frame %0d item %0d", item_tag(p), f, p), o1r[tag_f], o1i[tag_f], er, ei);
      end
      if (f > 0) chk($sformatf("R7 frame %0d mismatching items", f), fm, 0, 0, 0);
    end

    // halving stage under stalls
    chk("R2 R10 halving output count", ns, 0, ks, 0);
    chk("R2 latency two cycles", lat_bad, 0, 0, 0);
    chk("R2 R10 output held while idle", hold_bad, 0, 0, 0);
    for (int f = 0; f < NF; f++)
      for (int p = 0; p < N; p++) begin
        exp_item(f, p, 1'b1, er, ei);
        chk($sformatf("R9 R10 frame %0d item %0d", f, p), osr[f*N+12+p], osi[f*N+12+p], er, ei);
      end

    // twiddle between stages, then the LEN=2 stage
    for (int f = 0; f < NF; f++)
      for (int p = 0; p < N; p++) begin
        int e, zr, zi;
        real ang;
        e = (p % 4) * ((p / 8) + 2 * ((p / 4) % 2));
        ang = 2.0 * 3.14159265358979 * e / 16.0;
        zr = o1r[f*N+12+p]; zi = o1i[f*N+12+p];
        t2r[f*N+p] = rnd(zr * $cos(ang) + zi * $sin(ang));
        t2i[f*N+p] = rnd(zi * $cos(ang) - zr * $sin(ang));
      end
    for (int t = 0; t < NF*N + 3; t++) begin
      v2 = 1'b1; sel2 = 2'(t % 4);
      re2 = (t < NF*N) ? DW2'(t2r[t]) : '0;
      im2 = (t < NF*N) ? DW2'(t2i[t]) : '0;
      @(negedge clk);
    end
    v2 = 1'b0;
    repeat (4) @(negedge clk);

    chk("R2 second-stage output count", n2, 0, NF*N + 3, 0);
    for (int f = 0; f < NF; f++)
      for (int q = 0; q < N; q++) begin
        int k, gr, gi;
        real sr, si, ang, dr, di;
        k = ((q & 1) << 3) | ((q & 2) << 1) | ((q & 4) >> 1) | ((q & 8) >> 3);
        sr = 0.0; si = 0.0;
        for (int n = 0; n < N; n++) begin
          ang = 2.0 * 3.14159265358979 * ((n * k) % N) / 16.0;
          sr = sr + xr[f*N+n] * $cos(ang) + xi[f*N+n] * $sin(ang);
          si = si + xi[f*N+n] * $cos(ang) - xr[f*N+n] * $sin(ang);
        end
        gr = o2r[f*N+3+q]; gi = o2i[f*N+3+q];
        dr = gr - sr; di = gi - si;
        checks++;
        if (dr > 4.0 || dr < -4.0 || di > 4.0 || di < -4.0) begin
          bad++;
          $display("FAIL R11 frame %0d bin %0d got (%0d,%0d) expected (%0d,%0d)",
                   f, k, gr, gi, rnd(sr), rnd(si));
        end
      end

    done = 1;
    finish_run();
  end

endmodule